// File: doc/BRIEF.md
# Memory Size Probe

This block is a small bus master. On request it works out whether a RAM answers at a given base address and, if so, how many bytes it holds. It issues 32-bit single reads and writes on a plain request/acknowledge port. It first checks that the memory holds two complementary patterns. It then finds the size by looking for the point where a growing address offset folds back onto the first word. The result is a byte count, and zero means that no working memory was found.

Only the two words at byte offsets 0 and 4 are disturbed. Both are read and kept at the start and written back at the end, whatever the outcome. The test is only meaningful for memories whose size is a power of two. The caller gives a power-of-two upper limit. If no fold-back is seen below that limit, the limit itself is reported.

Each probe pattern write to word 0 is followed by a write of the opposite value to word 4. An open data bus that merely holds the last driven value therefore cannot pass as memory.

Top module: `mem_size_probe`

## Requirements
- R1: After a start request is accepted, the first two transfers are reads of the words at base+0 and base+4.
- R2: Presence pass one writes 0x5555AAAA to base+0, then 0xAAAA5555 to base+4, then reads base+0. Any other value read back ends the probe with size 0.
- R3: Presence pass two writes 0xAAAA5555 to base+0, then 0x5555AAAA to base+4, then reads base+0. Any other value read back ends the probe with size 0.
- R4: Sizing tries offsets 4, 8, 16, and so on. For each offset it reads base+offset, writes the bitwise inverse of that value to base+0, reads base+0, and then reads base+offset again. If the last two reads are equal, the size is that offset.
- R5: Sizing stops before testing any offset that is at or above the limit. In that case the size is the limit, so a limit of 4 or less is reported without any sizing step.
- R6: The last two transfers of every probe, including one that ends with size 0, write the kept values back to base+0 and then to base+4. No write ever goes to any address other than these two.
- R7: `done` is high for exactly one cycle, with `size_out` holding the result. `busy` is high from the cycle after the start is accepted up to and including the `done` cycle.
- R8: A start request while `busy` is high, including in the `done` cycle, has no effect. The base and limit in use stay the same, and no new probe follows.
- R9: A request holds its address, direction and write data unchanged until the cycle in which it is acknowledged. Each acknowledge completes exactly one transfer.
- R10: While reset is held and after it is released, no request is made, `busy` and `done` are low, and `size_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a probe when idle |
| base_addr | input | ADDR_W | Byte address of the memory's first word |
| max_size | input | ADDR_W | Power-of-two upper limit in bytes |
| busy | output | 1 | Probe in progress |
| done | output | 1 | One-cycle result strobe |
| size_out | output | ADDR_W | Detected size in bytes, 0 when absent or faulty |
| mem_req | output | 1 | Transfer request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | ADDR_W | Transfer byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Transfer completes in this cycle |
| mem_rdata | input | 32 | Read data, valid with the acknowledge |

## Verification
The case that needs care is a new start request arriving in the same cycle as the result strobe, when the probe is finishing but not yet idle. The bench raises `start` inside the very cycle in which `done` is high. It then watches the next few cycles: `mem_req` and `busy` must stay low, and no second result may appear. A second case is a start request that arrives partway through a probe with a different base address. The bench judges it by comparing every transfer that follows against the sequence it predicted for the original base.

// File: rtl/msp_pkg.sv
// Shared types and constants for the memory size probe.
// Assumes a 32-bit data path.
package msp_pkg;

    localparam int unsigned DATA_W = 32;
    localparam logic [DATA_W-1:0] PAT_A = 32'h5555_AAAA;
    localparam logic [DATA_W-1:0] PAT_B = 32'hAAAA_5555;

    typedef enum logic [4:0] {
        S_IDLE,
        S_SAVE0,
        S_SAVE4,
        S_PA0,
        S_PA4,
        S_PACHK,
        S_PB0,
        S_PB4,
        S_PBCHK,
        S_STEP,
        S_TRD,
        S_TINV,
        S_ZRD,
        S_TRD2,
        S_RST0,
        S_RST4,
        S_DONE
    } probe_state_e;

endpackage

// File: rtl/msp_offset_walker.sv
// Doubling test offset for the sizing loop.
// Loads 4, shifts left by one on each advance and flags when the offset
// reaches the limit. Assumes the limit is at most 2**(ADDR_W-1), so the
// shift never overflows before the limit is met.
module msp_offset_walker #(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              advance,
    input  logic [ADDR_W-1:0] limit,
    output logic [ADDR_W-1:0] ofs,
    output logic              at_limit
);

    localparam logic [ADDR_W-1:0] FIRST_OFS = ADDR_W'(4);

    // Hold the current test offset; restart at 4 or double.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs <= FIRST_OFS;
        end else if (load) begin
            ofs <= FIRST_OFS;
        end else if (advance) begin
            ofs <= ofs << 1;
        end
    end

    // Limit reached once the offset is no longer below it.
    always_comb at_limit = (ofs >= limit);

    // R4
    ofs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(ofs));

endmodule

// File: rtl/msp_word_capture.sv
// Captures read data needed later in a probe: the two saved words and
// the two sizing samples. A word is taken only when a read in the
// matching state is acknowledged.
module msp_word_capture
    import msp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  probe_state_e      state,
    input  logic              xfer,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] save0,
    output logic [DATA_W-1:0] save4,
    output logic [DATA_W-1:0] tval,
    output logic [DATA_W-1:0] zval
);

    // Latch read data into the register that belongs to the active state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            save0 <= '0;
            save4 <= '0;
            tval  <= '0;
            zval  <= '0;
        end else if (xfer) begin
            case (state)
                S_SAVE0: save0 <= rdata;
                S_SAVE4: save4 <= rdata;
                S_TRD:   tval  <= rdata;
                S_ZRD:   zval  <= rdata;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/msp_bus_drive.sv
// Decodes the probe state into one bus request: direction, address and
// write data. Pure logic. The request stays unchanged for as long as the
// state and the captured words do, which holds it steady until the
// acknowledge.
module msp_bus_drive
    import msp_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  probe_state_e      state,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] ofs,
    input  logic [DATA_W-1:0] save0,
    input  logic [DATA_W-1:0] save4,
    input  logic [DATA_W-1:0] tval,
    output logic              req,
    output logic              we,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata
);

    localparam logic [ADDR_W-1:0] WORD1 = ADDR_W'(4);

    // Choose the transfer that belongs to each bus state.
    always_comb begin
        req   = 1'b1;
        we    = 1'b0;
        addr  = base;
        wdata = '0;
        case (state)
            S_SAVE0: ;
            S_SAVE4: addr = base + WORD1;
            S_PA0:   begin we = 1'b1; wdata = PAT_A; end
            S_PA4:   begin we = 1'b1; addr = base + WORD1; wdata = PAT_B; end
            S_PACHK: ;
            S_PB0:   begin we = 1'b1; wdata = PAT_B; end
            S_PB4:   begin we = 1'b1; addr = base + WORD1; wdata = PAT_A; end
            S_PBCHK: ;
            S_TRD:   addr = base + ofs;
            S_TINV:  begin we = 1'b1; wdata = ~tval; end
            S_ZRD:   ;
            S_TRD2:  addr = base + ofs;
            S_RST0:  begin we = 1'b1; wdata = save0; end
            S_RST4:  begin we = 1'b1; addr = base + WORD1; wdata = save4; end
            default: req = 1'b0;
        endcase
    end

endmodule

// File: rtl/mem_size_probe.sv
// Non-destructive memory size probe.
// Runs two complementary presence checks on word 0. It then sizes the
// memory by finding the doubling offset that aliases onto word 0, and
// finally writes back the two words it disturbed. Assumes the memory
// size and max_size are powers of two, with max_size <= 2**(ADDR_W-1).
module mem_size_probe
    import msp_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W-1:0] max_size,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] size_out,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam logic [ADDR_W-1:0] WORD1 = ADDR_W'(4);

    probe_state_e      state;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] max_q;
    logic [ADDR_W-1:0] size_q;
    logic [ADDR_W-1:0] ofs;
    logic              at_limit;
    logic [DATA_W-1:0] save0, save4, tval, zval;
    logic              xfer;
    logic              walk_load, walk_adv;

    // A transfer completes when a request meets its acknowledge.
    always_comb xfer = mem_req && mem_ack;

    // Restart the offset when pass two succeeds; double it on a miss.
    always_comb begin
        walk_load = (state == S_PBCHK) && xfer && (mem_rdata == PAT_B);
        walk_adv  = (state == S_TRD2) && xfer && (mem_rdata != zval);
    end

    // Probe sequencer: latch arguments, step through transfers, set result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            base_q <= '0;
            max_q  <= '0;
            size_q <= '0;
        end else begin
            case (state)
                S_IDLE: if (start) begin
                    base_q <= base_addr;
                    max_q  <= max_size;
                    state  <= S_SAVE0;
                end
                S_SAVE0: if (xfer) state <= S_SAVE4;
                S_SAVE4: if (xfer) state <= S_PA0;
                S_PA0:   if (xfer) state <= S_PA4;
                S_PA4:   if (xfer) state <= S_PACHK;
                S_PACHK: if (xfer) begin
                    if (mem_rdata != PAT_A) begin
                        size_q <= '0;
                        state  <= S_RST0;
                    end else begin
                        state  <= S_PB0;
                    end
                end
                S_PB0:   if (xfer) state <= S_PB4;
                S_PB4:   if (xfer) state <= S_PBCHK;
                S_PBCHK: if (xfer) begin
                    if (mem_rdata != PAT_B) begin
                        size_q <= '0;
                        state  <= S_RST0;
                    end else begin
                        state  <= S_STEP;
                    end
                end
                S_STEP: begin
                    if (at_limit) begin
                        size_q <= max_q;
                        state  <= S_RST0;
                    end else begin
                        state  <= S_TRD;
                    end
                end
                S_TRD:   if (xfer) state <= S_TINV;
                S_TINV:  if (xfer) state <= S_ZRD;
                S_ZRD:   if (xfer) state <= S_TRD2;
                S_TRD2:  if (xfer) begin
                    if (mem_rdata == zval) begin
                        size_q <= ofs;
                        state  <= S_RST0;
                    end else begin
                        state  <= S_STEP;
                    end
                end
                S_RST0:  if (xfer) state <= S_RST4;
                S_RST4:  if (xfer) state <= S_DONE;
                S_DONE:  state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // Status outputs follow the sequencer state.
    always_comb begin
        busy     = (state != S_IDLE);
        done     = (state == S_DONE);
        size_out = size_q;
    end

    msp_offset_walker #(.ADDR_W(ADDR_W)) walker_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (walk_load),
        .advance  (walk_adv),
        .limit    (max_q),
        .ofs      (ofs),
        .at_limit (at_limit)
    );

    msp_word_capture capture_i (
        .clk   (clk),
        .rst_n (rst_n),
        .state (state),
        .xfer  (xfer),
        .rdata (mem_rdata),
        .save0 (save0),
        .save4 (save4),
        .tval  (tval),
        .zval  (zval)
    );

    msp_bus_drive #(.ADDR_W(ADDR_W)) drive_i (
        .state (state),
        .base  (base_q),
        .ofs   (ofs),
        .save0 (save0),
        .save4 (save4),
        .tval  (tval),
        .req   (mem_req),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wdata)
    );

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we)
                                   && $stable(mem_addr) && $stable(mem_wdata)));

    // R6
    wr_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_addr == base_q || mem_addr == base_q + WORD1));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    size_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (size_out <= max_q && $countones(size_out) <= 1));

    // R8
    arg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(base_q) && $stable(max_q)));

    // R1
    first_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (mem_req && !mem_we && mem_addr == base_q));

endmodule

// File: tb/mem_size_probe_tb.sv
module mem_size_probe_tb_top;

    localparam int AW    = 16;
    localparam int WORDS = 1024;
    localparam int WDOG  = 150000;

    typedef struct packed {
        logic          we;
        logic [AW-1:0] addr;
        logic [31:0]   wdata;
    } xact_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic [AW-1:0] max_size = '0;
    logic          busy, done;
    logic [AW-1:0] size_out;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic          mem_ack = 1'b0;
    logic [31:0]   mem_rdata = '0;

    always #2 clk = ~clk;

    mem_size_probe #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .max_size(max_size), .busy(busy), .done(done), .size_out(size_out),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    logic [31:0]   mem [WORDS];
    int            mem_words = WORDS;
    bit            present = 1'b1;
    logic [31:0]   stuck = '0;
    logic [31:0]   bus_last = '0;
    logic [AW-1:0] mbase = '0;
    int            lat_cfg = 0;
    int            lat_cnt = 0;
    xact_t         exp_q[$];
    int            exp_size = 0;
    bit            model_busy = 1'b0;
    bit            done_seen = 1'b0;
    int            n_chk = 0;
    int            n_fail = 0;
    int            cyc = 0;

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Memory behaviour: aliasing by size, read-only stuck bits, open bus.
    task automatic access(input bit we, input logic [AW-1:0] a,
                          input logic [31:0] wd, output logic [31:0] rd);
        int idx;
        rd = '0;
        if (!present) begin
            if (we) bus_last = wd;
            else    rd = bus_last;
        end else begin
            idx = int'((a - mbase) >> 2) & (mem_words - 1);
            if (we) begin
                mem[idx] = wd;
                bus_last = wd;
            end else begin
                rd = mem[idx] | stuck;
                bus_last = rd;
            end
        end
    endtask

    task automatic ex(input bit we, input logic [AW-1:0] a,
                      input logic [31:0] wd, output logic [31:0] rd);
        xact_t x;
        x.we = we; x.addr = a; x.wdata = wd;
        exp_q.push_back(x);
        access(we, a, wd, rd);
    endtask

    // Predict the transfer list and result from the requirements.
    task automatic build(input logic [AW-1:0] b, input int mx);
        logic [31:0] snap [WORDS];
        logic [31:0] snap_bus, s0, s4, v, t, z, t2;
        int sz;
        snap = mem;
        snap_bus = bus_last;
        exp_q.delete();
        ex(0, b, '0, s0);
        ex(0, b + AW'(4), '0, s4);
        ex(1, b, 32'h5555AAAA, v);
        ex(1, b + AW'(4), 32'hAAAA5555, v);
        ex(0, b, '0, v);
        if (v != 32'h5555AAAA) sz = 0;
        else begin
            ex(1, b, 32'hAAAA5555, v);
            ex(1, b + AW'(4), 32'h5555AAAA, v);
            ex(0, b, '0, v);
            if (v != 32'hAAAA5555) sz = 0;
            else begin
                sz = -1;
                for (int o = 4; o < mx && sz < 0; o = o * 2) begin
                    ex(0, b + AW'(o), '0, t);
                    ex(1, b, ~t, v);
                    ex(0, b, '0, z);
                    ex(0, b + AW'(o), '0, t2);
                    if (z == t2) sz = o;
                end
                if (sz < 0) sz = mx;
            end
        end
        ex(1, b, s0, v);
        ex(1, b + AW'(4), s4, v);
        exp_size = sz;
        mem = snap;
        bus_last = snap_bus;
    endtask

    // Responder and per-clock comparison against the model.
    initial begin
        logic [31:0] rd;
        xact_t h;
        forever begin
            @(negedge clk);
            cyc++;
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                if (lat_cnt < lat_cfg) lat_cnt++;
                else begin
                    lat_cnt = 0;
                    if (exp_q.size() == 0) begin
                        chk(0, "R6 unexpected transfer", 64'(mem_addr), 64'(0));
                    end else begin
                        h = exp_q.pop_front();
                        // R1 R2 R3 R4 R6 R9: transfer order and content
                        chk(mem_we == h.we && mem_addr == h.addr &&
                            (!h.we || mem_wdata == h.wdata),
                            "R1/R2/R3/R4/R6/R9 transfer",
                            {15'd0, mem_we, mem_addr, mem_wdata},
                            {15'd0, h.we, h.addr, h.wdata});
                    end
                    access(mem_we, mem_addr, mem_wdata, rd);
                    mem_rdata = rd;
                    mem_ack = 1'b1;
                end
            end
            // R7 busy window
            chk(busy == model_busy, "R7 busy", 64'(busy), 64'(model_busy));
            if (done) begin
                chk(size_out == AW'(exp_size), "R4/R5 size", 64'(size_out), 64'(exp_size));
                chk(exp_q.size() == 0, "R6 all transfers done", 64'(exp_q.size()), 64'(0));
                model_busy = 1'b0;
                done_seen = 1'b1;
            end
            if (cyc > WDOG) begin
                n_fail++;
                $display("FAIL watchdog expired at cycle %0d", cyc);
                $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
                $finish;
            end
        end
    end

    task automatic preload(input int seed);
        for (int i = 0; i < WORDS; i++)
            mem[i] = (32'(i) * 32'h9E3779B1) ^ 32'(seed);
    endtask

    // poke: 0 none, 1 start mid-run, 2 start in the done cycle
    task automatic run(input logic [AW-1:0] b, input int mx, input int lat,
                       input int poke, input string tag);
        logic [31:0] o0, o1;
        mbase = b;
        lat_cfg = lat;
        lat_cnt = 0;
        o0 = mem[0];
        o1 = mem[1];
        build(b, mx);
        done_seen = 1'b0;
        @(negedge clk); #1;
        base_addr = b;
        max_size = AW'(mx);
        start = 1'b1;
        model_busy = 1'b1;
        @(negedge clk); #1;
        start = 1'b0;
        base_addr = '1;
        if (poke == 1) begin
            repeat (7) @(negedge clk);
            #1;
            start = 1'b1;
            base_addr = b + AW'(16);
            max_size = AW'(8);
            @(negedge clk); #1;
            start = 1'b0;
        end
        wait (done_seen);
        if (poke == 2) begin
            #1;
            start = 1'b1;
            base_addr = b;
            @(negedge clk); #1;
            start = 1'b0;
            repeat (3) begin
                @(negedge clk); #1;
                // R8 start in done cycle ignored
                chk(!mem_req && !busy, "R8 start in done cycle",
                    64'({mem_req, busy}), 64'(0));
            end
        end
        if (present) begin
            // R6 both words written back
            chk(mem[0] == (o0 | stuck) && mem[1] == (o1 | stuck),
                {"R6 restore ", tag}, {mem[0], mem[1]}, {o0 | stuck, o1 | stuck});
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        preload(32'h1234_5678);
        repeat (3) begin
            @(negedge clk);
            // R10 during reset
            chk(!mem_req && !busy && !done && size_out == '0, "R10 reset",
                64'({mem_req, busy, done, size_out}), 64'(0));
        end
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R10 after release
        chk(!mem_req && !busy && !done && size_out == '0, "R10 idle",
            64'({mem_req, busy, done, size_out}), 64'(0));

        // R4 wrap at 256 bytes
        present = 1; stuck = '0; mem_words = 64;
        run(16'h0000, 4096, 0, 0, "R4 256B");
        // R5 memory as large as the limit
        mem_words = 1024; preload(32'hA5A5_0F0F);
        run(16'h0000, 4096, 1, 0, "R5 full");
        // R4 smallest memory; R8 start mid-run
        mem_words = 2; preload(32'h0BAD_F00D);
        run(16'h0000, 1024, 2, 1, "R4 8B");
        // R2 no memory; R8 start in done cycle
        present = 0; bus_last = 32'h0;
        run(16'h0400, 1024, 0, 2, "R2 absent");
        // R3 stuck bit passes pass one, fails pass two
        present = 1; stuck = 32'h2; mem_words = 1024; preload(32'h7777_0000);
        run(16'h0000, 1024, 1, 0, "R3 stuck");
        // R5 limit of 4 skips sizing
        stuck = '0; mem_words = 256; preload(32'h3C3C_C3C3);
        run(16'h2000, 4, 0, 0, "R5 tiny limit");
        // R5 size equal to limit at a nonzero base
        mem_words = 128; preload(32'hDEAD_0001);
        run(16'h1000, 512, 3, 0, "R5 equal");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule